// File: doc/BRIEF.md
# Processor Interrupt Request Front-End

This block stands between two raw interrupt pins and an instruction sequencer. It decides, at each instruction boundary, whether the core enters an interrupt handler and which 8-bit type number the handler uses. One pin carries an urgent request that cannot be disabled. This request is taken on a rising edge, but only if the pin then stays high for a minimum time. Once qualified, it is held in a latch until it is serviced. The other pin carries an ordinary level request. The core looks at it only in the last cycle of an instruction, and only when the enable flag is set.

The sequencer marks the last cycle of every instruction with a one-cycle strobe and supplies the enable flag and the single-step flag. The block answers with a one-cycle take pulse and a type number. For a maskable request, it first runs a two-pulse acknowledge exchange with an external interrupt controller. The controller places the type number on the bus during the second pulse.

Top module: `cpu_irq_frontend`

## Requirements
- R1: An urgent request is taken on a low-to-high change of the urgent pin. Holding the pin high after one serviced request raises no further request.
- R2: The urgent pin must be high on at least 3 consecutive clock samples (parameter NM_MIN_HIGH) after passing a 2-stage synchroniser. A pulse of 1 or 2 samples is discarded.
- R3: A qualified urgent request waits in a latch for the next boundary strobe. take_irq pulses for one cycle, in the cycle right after the strobe cycle.
- R4: An urgent request is taken regardless of ie_flag. Its type number is 2, and irq_ack stays low.
- R5: At a boundary, the order of precedence is: urgent request, then maskable request, then single-step.
- R6: The maskable pin is a level, sampled only in a boundary strobe cycle. It is taken only when ie_flag is 1 in that cycle. With ie_flag at 0, no acknowledge and no take occur.
- R7: A taken maskable request drives irq_ack high in the cycle after the strobe, low in the next cycle, and high in the one after that. ext_vec is captured in that second high cycle. take_irq follows in the next cycle, carrying the captured value. irq_vec holds its value between take pulses.
- R8: With tf_flag set and no other request, a boundary produces a take with type number 1 and no acknowledge.
- R9: Taking an urgent request clears its latch. A new request that qualifies in the same cycle stays latched and is taken at the following boundary.
- R10: After reset, take_irq and irq_ack are 0 and irq_vec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nm_pin | input | 1 | Raw urgent (non-maskable) request pin |
| mk_pin | input | 1 | Raw maskable request pin |
| insn_end | input | 1 | Strobe in the last cycle of each instruction |
| ie_flag | input | 1 | Interrupt-enable flag from the sequencer |
| tf_flag | input | 1 | Single-step flag from the sequencer |
| ext_vec | input | 8 | Type number from the external controller |
| irq_ack | output | 1 | Acknowledge toward the external controller |
| take_irq | output | 1 | One-cycle pulse: enter a handler |
| irq_vec | output | 8 | Type number for the handler |

## Verification
The properties assume two things about the sequencer. It never places boundary strobes in two adjacent cycles, and it raises no strobe while an acknowledge exchange is running. They also assume the maskable pin is stable for the two synchroniser cycles before a boundary. The stimulus meets these assumptions. Each scenario changes pins only at falling edges, leaves six idle cycles before a single-cycle strobe, and waits out the whole exchange before the next strobe.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ACK1 = 2'd1,
      SEQ_GAP  = 2'd2,
      SEQ_ACK2 = 2'd3
   } ack_state_e;
endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqfe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqfe_edge_qual.sv
module irqfe_edge_qual #(
   parameter int MIN_HIGH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic clr,
   output logic pend
);
   generate
      if (MIN_HIGH < 1) begin : g_bad_min
         $error("irqfe_edge_qual: MIN_HIGH must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(MIN_HIGH + 1);

   logic          armed;
   logic [CW-1:0] run;
   logic          hit;

   assign hit = lvl && armed && (run == CW'(MIN_HIGH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         run   <= '0;
         pend  <= 1'b0;
      end else begin
         if (!lvl) begin
            armed <= 1'b1;
            run   <= '0;
         end else if (armed) begin
            if (hit) begin
               armed <= 1'b0;
               run   <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end
         pend <= hit | (pend & ~clr);
      end
   end
endmodule

// File: rtl/irqfe_seq.sv
module irqfe_seq
   import irqfe_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int NM_VEC   = 2,
   parameter int STEP_VEC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             insn_end,
   input  logic             nm_pend,
   input  logic             mk_lvl,
   input  logic             ie_flag,
   input  logic             tf_flag,
   input  logic [VEC_W-1:0] ext_vec,
   output logic             nm_clr,
   output logic             irq_ack,
   output logic             take_irq,
   output logic [VEC_W-1:0] irq_vec
);
   ack_state_e state;
   logic       at_boundary;

   assign at_boundary = (state == SEQ_IDLE) && insn_end;
   assign nm_clr      = at_boundary && nm_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         irq_ack  <= 1'b0;
         take_irq <= 1'b0;
         irq_vec  <= '0;
      end else begin
         irq_ack  <= 1'b0;
         take_irq <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (at_boundary) begin
                  if (nm_pend) begin
                     take_irq <= 1'b1;
                     irq_vec  <= VEC_W'(NM_VEC);
                  end else if (mk_lvl && ie_flag) begin
                     state   <= SEQ_ACK1;
                     irq_ack <= 1'b1;
                  end else if (tf_flag) begin
                     take_irq <= 1'b1;
                     irq_vec  <= VEC_W'(STEP_VEC);
                  end
               end
            end
            SEQ_ACK1: state <= SEQ_GAP;
            SEQ_GAP: begin
               state   <= SEQ_ACK2;
               irq_ack <= 1'b1;
            end
            SEQ_ACK2: begin
               state    <= SEQ_IDLE;
               take_irq <= 1'b1;
               irq_vec  <= ext_vec;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cpu_irq_frontend.sv
module cpu_irq_frontend #(
   parameter int VEC_W       = 8,
   parameter int NM_VEC      = 2,
   parameter int STEP_VEC    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int NM_MIN_HIGH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nm_pin,
   input  logic             mk_pin,
   input  logic             insn_end,
   input  logic             ie_flag,
   input  logic             tf_flag,
   input  logic [VEC_W-1:0] ext_vec,
   output logic             irq_ack,
   output logic             take_irq,
   output logic [VEC_W-1:0] irq_vec
);
   generate
      if (VEC_W < 2) begin : g_bad_width
         $error("cpu_irq_frontend: VEC_W must be at least 2");
      end
      if (NM_VEC >= (1 << VEC_W) || STEP_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("cpu_irq_frontend: fixed type numbers must fit VEC_W");
      end
      if (NM_VEC == STEP_VEC) begin : g_same_vec
         $error("cpu_irq_frontend: fixed type numbers must differ");
      end
   endgenerate

   logic [1:0] pins_q;
   logic       nm_pend;
   logic       nm_clr;

   irqfe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mk_pin, nm_pin}),
      .q     (pins_q)
   );

   irqfe_edge_qual #(.MIN_HIGH(NM_MIN_HIGH)) u_nm_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pins_q[0]),
      .clr   (nm_clr),
      .pend  (nm_pend)
   );

   irqfe_seq #(.VEC_W(VEC_W), .NM_VEC(NM_VEC), .STEP_VEC(STEP_VEC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .insn_end (insn_end),
      .nm_pend  (nm_pend),
      .mk_lvl   (pins_q[1]),
      .ie_flag  (ie_flag),
      .tf_flag  (tf_flag),
      .ext_vec  (ext_vec),
      .nm_clr   (nm_clr),
      .irq_ack  (irq_ack),
      .take_irq (take_irq),
      .irq_vec  (irq_vec)
   );
endmodule

// File: rtl/irqfe_chk.sv
module irqfe_chk #(
   parameter int VEC_W  = 8,
   parameter int NM_VEC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_end,
   input logic             ie_flag,
   input logic             irq_ack,
   input logic             take_irq,
   input logic [VEC_W-1:0] irq_vec,
   input logic             nm_pend
);
   AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |=> !take_irq); // R3
   AST_TAKE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> ($past(insn_end) || $past(irq_ack))); // R3
   AST_ACK_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack); // R7
   AST_ACK_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (($past(insn_end) && $past(ie_flag)) || $past(irq_ack, 2))); // R6
   AST_NM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && $past(nm_pend) && $past(insn_end) && !$past(irq_ack))
         |-> (irq_vec == VEC_W'(NM_VEC))); // R5
   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !take_irq |-> $stable(irq_vec)); // R7
endmodule

bind cpu_irq_frontend irqfe_chk #(.VEC_W(VEC_W), .NM_VEC(NM_VEC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .insn_end (insn_end),
   .ie_flag  (ie_flag),
   .irq_ack  (irq_ack),
   .take_irq (take_irq),
   .irq_vec  (irq_vec),
   .nm_pend  (nm_pend)
);

// File: tb/tb_cpu_irq_frontend.sv
`timescale 1ns/1ps
module tb_cpu_irq_frontend;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nm_pin = 1'b0, mk_pin = 1'b0, insn_end = 1'b0;
   logic       ie_flag = 1'b0, tf_flag = 1'b0;
   logic [7:0] ext_vec = 8'h00;
   logic       irq_ack, take_irq;
   logic [7:0] irq_vec;
   int         checks = 0;
   int         errors = 0;

   always #2.5 clk = ~clk;

   cpu_irq_frontend dut (
      .clk(clk), .rst_n(rst_n), .nm_pin(nm_pin), .mk_pin(mk_pin),
      .insn_end(insn_end), .ie_flag(ie_flag), .tf_flag(tf_flag),
      .ext_vec(ext_vec), .irq_ack(irq_ack), .take_irq(take_irq),
      .irq_vec(irq_vec)
   );

   // kind: 0 nothing taken, 1 direct take, 2 acknowledge exchange
   typedef struct packed {
      logic [2:0] nmw;
      logic       mk;
      logic       ie;
      logic       tf;
      logic [7:0] ext;
      logic [1:0] kind;
      logic [7:0] expv;
   } row_t;

   localparam int NROWS = 9;
   localparam row_t TABLE [NROWS] = '{
      '{3'd3, 1'b0, 1'b0, 1'b0, 8'h00, 2'd1, 8'h02},  // R2 R4: exact width
      '{3'd2, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00},  // R2: too short
      '{3'd0, 1'b1, 1'b1, 1'b0, 8'h21, 2'd2, 8'h21},  // R6 R7
      '{3'd0, 1'b1, 1'b0, 1'b0, 8'h33, 2'd0, 8'h00},  // R6: masked
      '{3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 2'd1, 8'h01},  // R8
      '{3'd4, 1'b1, 1'b1, 1'b1, 8'h40, 2'd1, 8'h02},  // R5: urgent wins
      '{3'd0, 1'b1, 1'b1, 1'b1, 8'h9C, 2'd2, 8'h9C},  // R5: maskable over step
      '{3'd5, 1'b0, 1'b0, 1'b0, 8'h00, 2'd1, 8'h02},  // R4: enable clear
      '{3'd1, 1'b0, 1'b0, 1'b1, 8'h00, 2'd1, 8'h01}   // R2: 1-cycle pulse dropped
   };
   string row_req [NROWS] = '{"R2", "R2", "R7", "R6", "R8", "R5", "R5", "R4", "R2"};

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic boundary();
      insn_end = 1'b1;
      tick();
      insn_end = 1'b0;
   endtask

   task automatic pulse_nm(input int width);
      nm_pin = 1'b1;
      repeat (width) tick();
      nm_pin = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R10", "take after reset", {7'd0, take_irq}, 8'd0);
      chk("R10", "ack after reset", {7'd0, irq_ack}, 8'd0);
      chk("R10", "vec after reset", irq_vec, 8'd0);
      repeat (3) tick();

      for (int i = 0; i < NROWS; i++) begin
         mk_pin  = TABLE[i].mk;
         ie_flag = TABLE[i].ie;
         tf_flag = TABLE[i].tf;
         ext_vec = TABLE[i].ext;
         if (TABLE[i].nmw != 0) pulse_nm(int'(TABLE[i].nmw));
         repeat (6) tick();
         boundary();
         if (TABLE[i].kind == 2'd1) begin
            chk(row_req[i], "direct take", {7'd0, take_irq}, 8'd1);
            chk(row_req[i], "direct vec", irq_vec, TABLE[i].expv);
            chk(row_req[i], "direct ack", {7'd0, irq_ack}, 8'd0);
         end else if (TABLE[i].kind == 2'd2) begin
            chk(row_req[i], "ack pulse 1", {7'd0, irq_ack}, 8'd1);
            chk(row_req[i], "no early take", {7'd0, take_irq}, 8'd0);
            tick();
            chk(row_req[i], "ack gap", {7'd0, irq_ack}, 8'd0);
            tick();
            chk(row_req[i], "ack pulse 2", {7'd0, irq_ack}, 8'd1);
            tick();
            chk(row_req[i], "ack take", {7'd0, take_irq}, 8'd1);
            chk(row_req[i], "ack vec", irq_vec, TABLE[i].expv);
            chk(row_req[i], "ack low at take", {7'd0, irq_ack}, 8'd0);
         end else begin
            chk(row_req[i], "no take", {7'd0, take_irq}, 8'd0);
            chk(row_req[i], "no ack", {7'd0, irq_ack}, 8'd0);
            tick();
            chk(row_req[i], "still no take", {7'd0, take_irq}, 8'd0);
            chk(row_req[i], "still no ack", {7'd0, irq_ack}, 8'd0);
         end
         mk_pin = 1'b0; ie_flag = 1'b0; tf_flag = 1'b0;
         repeat (4) tick();
      end
      chk("R7", "vec held between takes", irq_vec, 8'h01);

      // R1: a level held high serves once only
      nm_pin = 1'b1;
      repeat (8) tick();
      boundary();
      chk("R1", "held level first take", {7'd0, take_irq}, 8'd1);
      chk("R1", "held level vec", irq_vec, 8'h02);
      repeat (3) tick();
      boundary();
      chk("R1", "held level no retake", {7'd0, take_irq}, 8'd0);
      nm_pin = 1'b0;
      repeat (5) tick();

      // R9: second edge qualifies in the very cycle the first is taken
      pulse_nm(3);
      repeat (4) tick();
      pulse_nm(3);
      tick();
      boundary();
      chk("R9", "first take", {7'd0, take_irq}, 8'd1);
      chk("R9", "first vec", irq_vec, 8'h02);
      repeat (2) tick();
      boundary();
      chk("R9", "relatched take", {7'd0, take_irq}, 8'd1);
      chk("R9", "relatched vec", irq_vec, 8'h02);
      repeat (2) tick();
      boundary();
      chk("R9", "latch cleared", {7'd0, take_irq}, 8'd0);

      // R3: latch waits across many cycles for a boundary
      pulse_nm(3);
      repeat (20) tick();
      chk("R3", "no take without boundary", {7'd0, take_irq}, 8'd0);
      boundary();
      chk("R3", "late boundary take", {7'd0, take_irq}, 8'd1);
      tick();
      chk("R3", "take lasts one cycle", {7'd0, take_irq}, 8'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule